// File: doc/BRIEF.md
# 32-Source Interrupt Controller with Normal/Critical Routing

This block collects 32 interrupt request lines into a status word. A small register bank drives two interrupt outputs to a processor: a normal one and a critical one. Each source is set to level or edge behaviour by its own trigger-type bit. Software uses the register bank to do four things: clear status bits with a write-one-to-clear access, set them through a separate write-one-to-set alias, mask them with an enable word, and choose per bit whether an enabled pending source drives the normal or the critical output.

The register port is a single-cycle read/write interface with a 4-bit word offset. A write takes effect at the clock edge where the write strobe is high. Read data is combinational while the read strobe is high. Inputs are sampled on the clock. Both outputs are registered and are evaluated from the state that is being loaded at the same edge.

Top module: `irq_ctrl32`

## Requirements
- R1: After reset, every readable offset returns 0 and both irq_norm and irq_crit are low.
- R2: Input irq_in[n] maps to status bit (31 - n). For example, input 0 is status bit 31 and input 31 is status bit 0.
- R3: With its trigger bit (offset 5) at 0, a source is level sensitive. Its status bit is set on the clock where the sampled input goes high and cleared on the clock where it goes low.
- R4: With its trigger bit at 1, a source is edge sensitive. A low-to-high change of the sampled input sets its status bit. A falling input, and an input held high after a clear, leave the bit unchanged.
- R5: A write to offset 0 clears each status bit written as 1. Any level-sensitive source whose input is currently high stays set.
- R6: A write to offset 1 ORs the write data into status. Reads of offset 0 and offset 1 both return status. A bit set this way on a level source with a steady low input stays set.
- R7: irq_norm is high when (status & enable & ~critsel) is non-zero. irq_crit is high when (status & enable & critsel) is non-zero. Enable is at offset 2 and critsel at offset 3. Both outputs change at the same clock edge as the write or input sample that causes the change.
- R8: A read of offset 6 returns status & enable. Writes to offsets 6 and 7 change nothing.
- R9: Offset 4 is a read/write polarity word with no effect on status or on either output.
- R10: Offsets 2, 3 and 5 read back the last value written. Offsets 7 through 15 read 0.
- R11: Every transfer completes in one cycle. A write is visible on reads and outputs right after its clock edge. rdata is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, index = source number |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
The bench probes the following corner cases:
- A write-one-to-clear on a level source whose input is still high. A design that drops the re-OR would lose an active interrupt until the input toggled.
- An edge source held high across a clear. A design that sets on level rather than on the rising edge would re-set the bit at once and make the clear useless.
- The critical routing, by enabling two sources and moving one between the outputs. This would expose a swapped or merged output equation.
- Reversed bit order, a polarity word that leaks into behaviour, and writes to the masked-status or vector offsets that alter state. Each of these would show up as a wrong status read-back.

// File: rtl/irq_ctrl32.sv
module irq_ctrl32 #(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  wdata,
  output logic [N-1:0]  rdata,
  output logic          irq_norm,
  output logic          irq_crit
);
  localparam logic [AW-1:0] OFS_STS  = AW'(0);
  localparam logic [AW-1:0] OFS_SET  = AW'(1);
  localparam logic [AW-1:0] OFS_EN   = AW'(2);
  localparam logic [AW-1:0] OFS_CRIT = AW'(3);
  localparam logic [AW-1:0] OFS_POL  = AW'(4);
  localparam logic [AW-1:0] OFS_TRIG = AW'(5);
  localparam logic [AW-1:0] OFS_MSK  = AW'(6);

  logic [N-1:0] status_q, en_q, crit_q, pol_q, trig_q, in_q;
  logic [N-1:0] in_s, rise, fall, st_in, st_n, en_n, crit_n;

  for (genvar n = 0; n < N; n++) begin : g_map
    assign in_s[N-1-n] = irq_in[n];
  end

  assign rise  = in_s & ~in_q;
  assign fall  = ~in_s & in_q;
  assign st_in = (status_q | rise) & ~(fall & ~trig_q);

  always_comb begin
    st_n = st_in;
    if (wr_en && addr == OFS_STS) st_n = (st_in & ~wdata) | (in_s & ~trig_q);
    if (wr_en && addr == OFS_SET) st_n = st_in | wdata;
  end

  assign en_n   = (wr_en && addr == OFS_EN)   ? wdata : en_q;
  assign crit_n = (wr_en && addr == OFS_CRIT) ? wdata : crit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
      crit_q   <= '0;
      pol_q    <= '0;
      trig_q   <= '0;
      in_q     <= '0;
      irq_norm <= 1'b0;
      irq_crit <= 1'b0;
    end else begin
      status_q <= st_n;
      en_q     <= en_n;
      crit_q   <= crit_n;
      in_q     <= in_s;
      if (wr_en && addr == OFS_POL)  pol_q  <= wdata;
      if (wr_en && addr == OFS_TRIG) trig_q <= wdata;
      irq_norm <= |(st_n & en_n & ~crit_n);
      irq_crit <= |(st_n & en_n & crit_n);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        OFS_STS, OFS_SET: rdata = status_q;
        OFS_EN:           rdata = en_q;
        OFS_CRIT:         rdata = crit_q;
        OFS_POL:          rdata = pol_q;
        OFS_TRIG:         rdata = trig_q;
        OFS_MSK:          rdata = status_q & en_q;
        default:          rdata = '0;
      endcase
    end
  end
endmodule

module irq_ctrl32_chk #(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [N-1:0]  wdata,
  input logic [N-1:0]  rdata,
  input logic          irq_norm,
  input logic          irq_crit,
  input logic [N-1:0]  status_q,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  crit_q
);
  a_r6_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1)) |=> ((status_q & $past(wdata)) == $past(wdata)));

  a_r7_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2) && wdata == '0) |=> (!irq_norm && !irq_crit));

  a_r7_crit_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> ((status_q & en_q & crit_q) != '0));

  a_r7_norm_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |-> ((status_q & en_q & ~crit_q) != '0));

  a_r8_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(6)) |-> ((rdata & ~en_q) == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > AW'(6)) |-> (rdata == '0));

  a_r11_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind irq_ctrl32 irq_ctrl32_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_norm(irq_norm), .irq_crit(irq_crit),
  .status_q(status_q), .en_q(en_q), .crit_q(crit_q)
);

// File: tb/irq_ctrl32_bench.sv
module irq_ctrl32_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_norm, irq_crit;
  int checks = 0, fails = 0;

  irq_ctrl32 u_irq_ctrl32 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic outs(input string req, input logic n, input logic c);
    chk({req, " norm"}, {31'd0, irq_norm}, {31'd0, n});
    chk({req, " crit"}, {31'd0, irq_crit}, {31'd0, c});
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) rd_chk("R1 reset read", 4'(a), 32'h0);
    outs("R1 reset", 1'b0, 1'b0);
  endtask

  task automatic t_mapping;
    drive(32'h8000_0001);
    rd_chk("R2 input0/31 order", 4'd0, 32'h8000_0001);
    drive(32'h0000_0000);
    rd_chk("R3 level clears on low", 4'd0, 32'h0);
  endtask

  task automatic t_level;
    wr(4'd2, 32'h1000_0000);
    drive(32'h0000_0008);
    rd_chk("R3 level set", 4'd0, 32'h1000_0000);
    outs("R3 level enabled", 1'b1, 1'b0);
    wr(4'd0, 32'h1000_0000);
    rd_chk("R5 level held high survives clear", 4'd0, 32'h1000_0000);
    outs("R5 output stays", 1'b1, 1'b0);
    drive(32'h0000_0000);
    rd_chk("R3 level falls", 4'd0, 32'h0);
    outs("R3 output drops", 1'b0, 1'b0);
  endtask

  task automatic t_edge;
    wr(4'd5, 32'h0800_0000);
    drive(32'h0000_0018);
    rd_chk("R4 edge rise sets", 4'd0, 32'h1800_0000);
    drive(32'h0000_0008);
    rd_chk("R4 edge fall keeps", 4'd0, 32'h1800_0000);
    wr(4'd0, 32'h1800_0000);
    rd_chk("R5 clear edge, keep level", 4'd0, 32'h1000_0000);
    drive(32'h0000_0018);
    wr(4'd0, 32'h0800_0000);
    @(negedge clk); @(negedge clk);
    rd_chk("R4 held high no reset", 4'd0, 32'h1000_0000);
    drive(32'h0000_0000);
    rd_chk("R4 cleanup", 4'd0, 32'h0);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_set_alias;
    wr(4'd1, 32'h0000_00F0);
    rd_chk("R6 set via alias", 4'd0, 32'h0000_00F0);
    rd_chk("R6 alias reads status", 4'd1, 32'h0000_00F0);
    @(negedge clk); @(negedge clk);
    rd_chk("R6 level low input keeps set", 4'd0, 32'h0000_00F0);
    wr(4'd0, 32'h0000_00F0);
    rd_chk("R5 clear alias bits", 4'd0, 32'h0);
  endtask

  task automatic t_routing;
    wr(4'd2, 32'h0000_0003);
    wr(4'd3, 32'h0000_0001);
    wr(4'd1, 32'h0000_0001);
    outs("R7 critical only", 1'b0, 1'b1);
    wr(4'd1, 32'h0000_0002);
    outs("R7 both", 1'b1, 1'b1);
    wr(4'd0, 32'h0000_0001);
    outs("R7 normal only", 1'b1, 1'b0);
    wr(4'd2, 32'h0);
    outs("R11 enable off next edge", 1'b0, 1'b0);
    rd_chk("R8 masked with enable off", 4'd6, 32'h0);
    wr(4'd2, 32'h0000_0003);
    rd_chk("R8 masked status", 4'd6, 32'h0000_0002);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    rd_chk("R8 ignored writes status", 4'd0, 32'h0000_0002);
    rd_chk("R8 ignored writes masked", 4'd6, 32'h0000_0002);
    rd_chk("R8 vector offset reads zero", 4'd7, 32'h0);
  endtask

  task automatic t_polarity;
    wr(4'd4, 32'hFFFF_FFFF);
    rd_chk("R9 polarity readback", 4'd4, 32'hFFFF_FFFF);
    rd_chk("R9 status untouched", 4'd0, 32'h0000_0002);
    outs("R9 outputs untouched", 1'b1, 1'b0);
  endtask

  task automatic t_readback;
    wr(4'd5, 32'h00A5_5A00);
    rd_chk("R10 enable readback", 4'd2, 32'h0000_0003);
    rd_chk("R10 critsel readback", 4'd3, 32'h0000_0001);
    rd_chk("R10 trigger readback", 4'd5, 32'h00A5_5A00);
    for (int a = 7; a < 16; a++) rd_chk("R10 unmapped zero", 4'(a), 32'h0);
    addr = 4'd0; #1;
    chk("R11 no read strobe", rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mapping;
    t_level;
    t_edge;
    t_set_alias;
    t_routing;
    t_polarity;
    t_readback;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule